// File: doc/BRIEF.md
# Dead-Time and Chopping Output Stage

This block is the output stage for one phase of a motor or power-converter PWM. It takes the ideal complementary requests for the high-side and low-side switches, which an upstream timing unit produces. It then applies the safety and gate-drive shaping that the switches need before they reach the pads.

There are two steps. First, a dead-time stage holds back every turn-on by a programmable number of clock cycles. A turn-off passes after the normal register latency. A side is never turned on while the opposite side is requested, so the two drive outputs cannot overlap. Second, a locally generated square-wave carrier can be ANDed into either drive output. This suits transformer-coupled gate drivers, which need a high-frequency signal. Each side also has an output enable. A shutdown input blanks both outputs combinationally, so it takes effect within the cycle it is raised.

Top module: `pwm_dtc_stage`

## Requirements
- R1: While `rst_n` is low, both drive outputs are 0 and the dead-time and carrier state returns to idle.
- R2: When one side's request is high and the other side's request is low at every edge, with `shutdown` low, that side's dead-time output turns on at the (D+1)-th such consecutive edge. D is `dead_cnt`. The turn-on is therefore D cycles later than a turn-off, and this holds for either side.
- R3: A side's dead-time output turns off at the first rising edge that samples its request low.
- R4: `drive_hi` and `drive_lo` are never 1 in the same cycle. While both requests are high, neither side turns on.
- R5: The carrier is a square wave that starts low after reset. It toggles after every `chop_div`+1 cycles, so it is high for exactly half of any whole number of periods.
- R6: With a side's chop enable at 1, that drive output is its dead-time output ANDed with the carrier. With the chop enable at 0, the dead-time output passes straight through.
- R7: A side's drive output is 0 while its output enable is 0.
- R8: `shutdown` forces both drive outputs to 0 combinationally, in the same cycle it is raised.
- R9: While `shutdown` is high, both dead-time stages are held idle. After release, a held request must wait the full dead time again before its output turns on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hi_req | input | 1 | Ideal high-side request |
| lo_req | input | 1 | Ideal low-side request |
| dead_cnt | input | DT_W | Dead time in cycles |
| chop_div | input | DIV_W | Carrier half-period minus one, in cycles |
| chop_en_hi | input | 1 | Apply carrier to high side |
| chop_en_lo | input | 1 | Apply carrier to low side |
| out_en_hi | input | 1 | High-side output enable |
| out_en_lo | input | 1 | Low-side output enable |
| shutdown | input | 1 | Forces both outputs off immediately |
| drive_hi | output | 1 | Final high-side drive |
| drive_lo | output | 1 | Final low-side drive |

## Verification
The dead-time property assumes that `dead_cnt` does not drop to zero in the cycle just after a request was sampled low. The bench changes `dead_cnt` and `chop_div` only while both requests are low, and it holds every input steady across each clock edge by driving it one nanosecond after the edge. Shutdown and output enables are assumed to be free to change in any cycle, and the random phase toggles them without restriction.

// File: rtl/dtc_pkg.sv
// Package: shared indices and the per-side control bundle for the
// dead-time and chopping output stage. Assumes exactly two sides.
package dtc_pkg;
    localparam int NUM_SIDES = 2;
    localparam int SIDE_HI   = 0;
    localparam int SIDE_LO   = 1;

    typedef struct packed {
        logic req;
        logic chop_en;
        logic out_en;
    } side_ctl_t;
endpackage

// File: rtl/dtc_deadband.sv
// Module: dtc_deadband
// Delays turn-on of one side by a programmable number of cycles. Turn-off
// follows the request with one register of latency. Turn-on is allowed only
// while the opposite request is low, so two instances never overlap.
// Assumes: dead_cnt stable while a count is running (shrinking it is tolerated).
module dtc_deadband #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_idle,
    input  logic             req_own,
    input  logic             req_other,
    input  logic [CNT_W-1:0] dead_cnt,
    output logic             dt_out
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] wait_q;
    logic             on_q;
    logic             arm;

    // Qualify the request: own side asked, other side quiet, no shutdown.
    always_comb arm = req_own && !req_other && !hold_idle;

    // Count the dead time, then latch the side on until the request drops.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm) begin
            wait_q <= '0;
            on_q   <= 1'b0;
        end else if (!on_q) begin
            if (wait_q >= dead_cnt) on_q <= 1'b1;
            else                    wait_q <= wait_q + ONE;
        end
    end

    assign dt_out = on_q;
endmodule

// File: rtl/dtc_carrier.sv
// Module: dtc_carrier
// Free-running 50% duty square wave. Toggles after half_div+1 cycles.
// Assumes: half_div may change at any time; the >= compare avoids a wrap.
module dtc_carrier #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half_div,
    output logic             carrier
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] tick_q;
    logic             wave_q;

    // Divide the clock and flip the wave at the end of each half period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= '0;
            wave_q <= 1'b0;
        end else if (tick_q >= half_div) begin
            tick_q <= '0;
            wave_q <= !wave_q;
        end else begin
            tick_q <= tick_q + ONE;
        end
    end

    assign carrier = wave_q;
endmodule

// File: rtl/dtc_gate.sv
// Module: dtc_gate
// Combinational output gating for one side: optional carrier mixing,
// output enable and immediate shutdown blanking. Assumes inputs are glitch
// tolerable at the pad (no output register, so shutdown acts at once).
module dtc_gate (
    input  logic dt_in,
    input  logic carrier,
    input  logic chop_en,
    input  logic out_en,
    input  logic shutdown,
    output logic drive
);
    logic mixed;

    // Mix in the carrier when chopping is selected for this side.
    always_comb mixed = chop_en ? (dt_in && carrier) : dt_in;

    // Apply enable and shutdown last so nothing upstream can bypass them.
    always_comb drive = mixed && out_en && !shutdown;
endmodule

// File: rtl/pwm_dtc_stage.sv
// Module: pwm_dtc_stage
// One phase output stage: per-side dead-time insertion followed by carrier
// mixing and gating. Assumes the ideal pair comes from a synchronous source
// in the same clock domain; shutdown may be asynchronous (combinational path).
module pwm_dtc_stage #(
    parameter int DT_W  = 8,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hi_req,
    input  logic             lo_req,
    input  logic [DT_W-1:0]  dead_cnt,
    input  logic [DIV_W-1:0] chop_div,
    input  logic             chop_en_hi,
    input  logic             chop_en_lo,
    input  logic             out_en_hi,
    input  logic             out_en_lo,
    input  logic             shutdown,
    output logic             drive_hi,
    output logic             drive_lo
);
    import dtc_pkg::*;

    dtc_pkg::side_ctl_t      ctl [NUM_SIDES];
    logic [NUM_SIDES-1:0]    req_v;
    logic [NUM_SIDES-1:0]    dt_v;
    logic [NUM_SIDES-1:0]    drv_v;
    logic                    carrier;

    // Bundle the per-side controls so both sides share one structure.
    always_comb begin
        ctl[SIDE_HI] = '{req: hi_req, chop_en: chop_en_hi, out_en: out_en_hi};
        ctl[SIDE_LO] = '{req: lo_req, chop_en: chop_en_lo, out_en: out_en_lo};
    end

    dtc_carrier #(.DIV_W(DIV_W)) u_carrier (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_div (chop_div),
        .carrier  (carrier)
    );

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        assign req_v[s] = ctl[s].req;

        dtc_deadband #(.CNT_W(DT_W)) u_deadband (
            .clk       (clk),
            .rst_n     (rst_n),
            .hold_idle (shutdown),
            .req_own   (req_v[s]),
            .req_other (req_v[NUM_SIDES-1-s]),
            .dead_cnt  (dead_cnt),
            .dt_out    (dt_v[s])
        );

        dtc_gate u_gate (
            .dt_in    (dt_v[s]),
            .carrier  (carrier),
            .chop_en  (ctl[s].chop_en),
            .out_en   (ctl[s].out_en),
            .shutdown (shutdown),
            .drive    (drv_v[s])
        );
    end

    assign drive_hi = drv_v[SIDE_HI];
    assign drive_lo = drv_v[SIDE_LO];
endmodule

// File: rtl/dtc_stage_chk.sv
// Module: dtc_stage_chk
// Port-level properties of pwm_dtc_stage, attached through bind.
module dtc_stage_chk #(
    parameter int DT_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            hi_req,
    input logic            lo_req,
    input logic [DT_W-1:0] dead_cnt,
    input logic            out_en_hi,
    input logic            out_en_lo,
    input logic            shutdown,
    input logic            drive_hi,
    input logic            drive_lo
);
    // R4
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(drive_hi && drive_lo));

    // R8
    shutdown_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> (!drive_hi && !drive_lo));

    // R7
    hi_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en_hi |-> !drive_hi);

    // R7
    lo_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en_lo |-> !drive_lo);

    // R3
    hi_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hi_req || lo_req) |=> !drive_hi);

    // R3
    lo_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lo_req || hi_req) |=> !drive_lo);

    // R2
    hi_deadtime_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!hi_req, 2) && $past(dead_cnt != '0, 1)) |-> !drive_hi);

    // R2
    lo_deadtime_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!lo_req, 2) && $past(dead_cnt != '0, 1)) |-> !drive_lo);
endmodule

bind pwm_dtc_stage dtc_stage_chk #(.DT_W(DT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hi_req    (hi_req),
    .lo_req    (lo_req),
    .dead_cnt  (dead_cnt),
    .out_en_hi (out_en_hi),
    .out_en_lo (out_en_lo),
    .shutdown  (shutdown),
    .drive_hi  (drive_hi),
    .drive_lo  (drive_lo)
);

// File: tb/pwm_dtc_stage_test.sv
module pwm_dtc_stage_test;
    localparam int DT_W  = 8;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             hi_req, lo_req;
    logic [DT_W-1:0]  dead_cnt;
    logic [DIV_W-1:0] chop_div;
    logic             chop_en_hi, chop_en_lo, out_en_hi, out_en_lo, shutdown;
    logic             drive_hi, drive_lo;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct packed { logic dt_hi; logic dt_lo; logic car; } exp_t;
    exp_t exp_q [$];

    always #4 clk = !clk;

    pwm_dtc_stage #(.DT_W(DT_W), .DIV_W(DIV_W)) uut (
        .clk(clk), .rst_n(rst_n), .hi_req(hi_req), .lo_req(lo_req),
        .dead_cnt(dead_cnt), .chop_div(chop_div),
        .chop_en_hi(chop_en_hi), .chop_en_lo(chop_en_lo),
        .out_en_hi(out_en_hi), .out_en_lo(out_en_lo),
        .shutdown(shutdown), .drive_hi(drive_hi), .drive_lo(drive_lo)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model from the requirements: advanced at every edge.
    int   m_whi = 0, m_wlo = 0, m_tick = 0;
    logic m_hi = 0, m_lo = 0, m_car = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_whi = 0; m_wlo = 0; m_tick = 0; m_hi = 0; m_lo = 0; m_car = 0;
        end else begin
            if (!(hi_req && !lo_req && !shutdown)) begin m_whi = 0; m_hi = 0; end
            else if (!m_hi) begin
                if (m_whi >= int'(dead_cnt)) m_hi = 1; else m_whi++;
            end
            if (!(lo_req && !hi_req && !shutdown)) begin m_wlo = 0; m_lo = 0; end
            else if (!m_lo) begin
                if (m_wlo >= int'(dead_cnt)) m_lo = 1; else m_wlo++;
            end
            if (m_tick >= int'(chop_div)) begin m_tick = 0; m_car = !m_car; end
            else m_tick++;
        end
        exp_q.push_back('{dt_hi: m_hi, dt_lo: m_lo, car: m_car});
    end

    // Monitor: pop the expected state and compare the gated outputs.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            logic eh, el;
            string tg;
            e  = exp_q.pop_front();
            eh = e.dt_hi && (chop_en_hi ? e.car : 1'b1) && out_en_hi && !shutdown;
            el = e.dt_lo && (chop_en_lo ? e.car : 1'b1) && out_en_lo && !shutdown;
            if (!rst_n)                 tg = "R1";
            else if (shutdown)          tg = "R8";
            else if (hi_req && lo_req)  tg = "R4";
            else if (chop_en_hi || chop_en_lo) tg = "R6";
            else if (!out_en_hi || !out_en_lo) tg = "R7";
            else                        tg = "R2";
            check({tg, " hi"}, drive_hi, eh);
            check({tg, " lo"}, drive_lo, el);
        end
    end

    task automatic step(); @(posedge clk); #1; endtask

    // Raise hi_req and confirm the output turns on exactly D cycles late.
    task automatic rise_check(input string tag, input int d);
        hi_req = 1;
        repeat (d) @(posedge clk);
        @(negedge clk); check({tag, " still off"}, drive_hi, 1'b0);
        @(negedge clk); check({tag, " now on"},    drive_hi, 1'b1);
        #1;
    endtask

    initial begin
        rst_n = 0; hi_req = 1; lo_req = 0; dead_cnt = 3; chop_div = 2;
        chop_en_hi = 0; chop_en_lo = 0; out_en_hi = 1; out_en_lo = 1; shutdown = 0;
        repeat (4) step();
        @(negedge clk);
        check("R1 reset hi", drive_hi, 1'b0);
        check("R1 reset lo", drive_lo, 1'b0);
        step(); hi_req = 0; rst_n = 1;
        repeat (3) step();

        // R2 dead time on the high side, D=3
        rise_check("R2 dead3", 3);
        // R3 turn-off after one edge
        @(posedge clk); #1; hi_req = 0;
        @(negedge clk); check("R3 before edge", drive_hi, 1'b1);
        @(negedge clk); check("R3 after edge", drive_hi, 1'b0);
        #1; repeat (2) step();

        // R2 with D=0
        dead_cnt = 0; step();
        rise_check("R2 dead0", 0);
        hi_req = 0; repeat (2) step();

        // R2 low side, D=2
        dead_cnt = 2; step();
        lo_req = 1; repeat (2) @(posedge clk);
        @(negedge clk); check("R2 lo still off", drive_lo, 1'b0);
        @(negedge clk); check("R2 lo now on", drive_lo, 1'b1);
        #1;
        // R4 both requested: low drops, high never turns on
        hi_req = 1; repeat (6) step();
        @(negedge clk);
        check("R4 both hi", drive_hi, 1'b0);
        check("R4 both lo", drive_lo, 1'b0);
        #1; lo_req = 0;
        // now high sees a clean request: D=2 dead time before turn-on
        repeat (2) @(posedge clk);
        @(negedge clk); check("R4 handover off", drive_hi, 1'b0);
        @(negedge clk); check("R4 handover on", drive_hi, 1'b1);
        #1;

        // R8 shutdown blanks in the same cycle
        @(posedge clk); #1; shutdown = 1;
        @(negedge clk); check("R8 same cycle", drive_hi, 1'b0);
        #1; repeat (3) step();
        // R9 release while request held: full dead time again
        shutdown = 0;
        rise_check("R9 restart", 2);

        // R7 output enable
        out_en_hi = 0;
        @(negedge clk); check("R7 enable off", drive_hi, 1'b0);
        #1; out_en_hi = 1;

        // R5 carrier 50% duty: 60 cycles = 10 periods with half length 3
        dead_cnt = 2; hi_req = 0; step(); chop_div = 2; step();
        hi_req = 1; chop_en_hi = 1; repeat (4) step();
        begin
            int highs = 0;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk); if (drive_hi) highs++;
            end
            check("R5 duty", highs == 30, 1'b1);
        end
        #1;
        chop_en_hi = 0;
        @(negedge clk); check("R6 passthrough", drive_hi, 1'b1);
        #1; hi_req = 0; repeat (2) step();

        // Random phase, scoreboard compares every cycle
        for (int n = 0; n < 3000; n++) begin
            if (!hi_req && !lo_req && ($urandom % 8 == 0)) begin
                dead_cnt = DT_W'($urandom % 5);
                chop_div = DIV_W'($urandom % 4);
            end
            if ($urandom % 6 == 0) hi_req = !hi_req;
            if ($urandom % 6 == 0) lo_req = !lo_req;
            if ($urandom % 20 == 0) chop_en_hi = !chop_en_hi;
            if ($urandom % 20 == 0) chop_en_lo = !chop_en_lo;
            out_en_hi = ($urandom % 16) != 0;
            out_en_lo = ($urandom % 16) != 0;
            shutdown  = ($urandom % 25) == 0;
            step();
        end
        @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule